// File: doc/BRIEF.md
# Bus Cycle Mode and Space Selector

This block sits in front of an address translator and decides, once per bus cycle, which 2-bit privilege mode and which address space (instruction or data) the translator should index with. It latches that decision when the bus-cycle-start strobe fires and holds it unchanged until the next strobe. The translator therefore sees a steady mode and space for the whole cycle.

The mode normally comes from the current-mode field of the processor status word. There are three overrides. A kernel data read forces kernel mode. A console cycle takes the console switches. A move-to/from-previous-space bus operation takes the previous-mode field.

The space defaults to data. Instruction space is chosen when any of several requests is active. Some of these requests are unconditional. Others are qualified by the decoded instruction's register fields. One of them is qualified by a flag that remembers whether the previous bus cycle used instruction space.

Top module: `bss_selector`

## Requirements
- R1: While rst_n is low and after its release, sel_mode is 2'b00 and sel_ispace is 0, and the stored previous-space flag reads as data space.
- R2: sel_mode and sel_ispace change only on a rising clk edge at which cycle_start is 1, and they take the values selected from the inputs present at that edge.
- R3: When ctl_kern_dread is 1 at a cycle start, the result is mode 2'b00 (kernel) and data space, whatever the other inputs are.
- R4: Otherwise, when ctl_console is 1, the mode is con_mode.
- R5: Otherwise, when both ctl_prev_op and dec_prev_insn are 1, the mode is psw_prev_mode. ctl_prev_op alone leaves the mode at psw_cur_mode.
- R6: With none of the overrides in R3 to R5 active, the mode is psw_cur_mode.
- R7: ctl_ifetch selects instruction space unconditionally, unless R3 applies.
- R8: Instruction space is also selected by each of these: ctl_src_pc with dec_src_pc; ctl_dst_pc with dec_dst_pc; ctl_dst_pc_np with dec_dst_pc and not dec_prev_insn; ctl_dst_pc_m2 with dec_dst_pc and dec_dst_m2. When its qualifier is false, a request has no effect.
- R9: ctl_prev_i with dec_prev_insn selects instruction space only when dec_ir15 is 0. A 1 on dec_ir15 marks the data variant, which stays in data space.
- R10: ctl_cont selects instruction space only if the previous cycle start chose instruction space. The stored flag is rewritten at every cycle start with the space chosen there, including cycles forced by R3.
- R11: ctl_con_space selects instruction space when con_ispace is 1.
- R12: With no instruction-space request active, the space is data (sel_ispace = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_start | input | 1 | Bus-cycle-start strobe; the selection is latched on this |
| psw_cur_mode | input | 2 | Current-mode field of the status word |
| psw_prev_mode | input | 2 | Previous-mode field of the status word |
| con_mode | input | 2 | Console mode switches |
| con_ispace | input | 1 | Console space switch, 1 = instruction |
| ctl_kern_dread | input | 1 | Force kernel data read |
| ctl_console | input | 1 | Console cycle, take mode from switches |
| ctl_prev_op | input | 1 | Bus operation of previous-space type |
| ctl_ifetch | input | 1 | Unconditional instruction-space request |
| ctl_src_pc | input | 1 | I request qualified by source register = PC |
| ctl_dst_pc | input | 1 | I request qualified by destination register = PC |
| ctl_dst_pc_np | input | 1 | I request: destination = PC and not a previous-space move |
| ctl_dst_pc_m2 | input | 1 | I request: destination = PC in mode 2 |
| ctl_prev_i | input | 1 | I request for the instruction-space previous move |
| ctl_cont | input | 1 | Continuation request, follows the stored flag |
| ctl_con_space | input | 1 | Console space request |
| dec_src_pc | input | 1 | Decode: source register is the PC |
| dec_dst_pc | input | 1 | Decode: destination register is the PC |
| dec_dst_m2 | input | 1 | Decode: destination mode is 2 |
| dec_prev_insn | input | 1 | Decode: move to/from previous space |
| dec_ir15 | input | 1 | Instruction bit 15, 1 = data variant |
| sel_mode | output | 2 | Latched mode for the translator |
| sel_ispace | output | 1 | Latched space, 1 = instruction |

## Verification
A wrong previous-space flag is invisible until a continuation request arrives. It then shows as a flipped sel_ispace one edge after that strobe. For this reason the bench chains cycle starts that alternate instruction and data and then issues continuations. A wrong priority among the mode overrides shows on sel_mode at the edge where two of them are active together. An output that changes without a strobe shows at the first clock edge after the inputs change mid-cycle.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

  typedef struct packed {
    logic ifetch;
    logic src_pc;
    logic dst_pc;
    logic dst_pc_np;
    logic dst_pc_m2;
    logic prev_i;
    logic cont;
    logic con_space;
  } ireq_t;

  typedef struct packed {
    logic src_pc;
    logic dst_pc;
    logic dst_m2;
    logic prev_insn;
    logic ir15;
  } idec_t;

  function automatic logic [MODE_W-1:0] pick_mode(
    input logic kern, input logic console, input logic prev_op,
    input logic prev_insn, input logic [MODE_W-1:0] cur,
    input logic [MODE_W-1:0] prv, input logic [MODE_W-1:0] con);
    if (kern)                      return MODE_KERNEL;
    else if (console)              return con;
    else if (prev_op && prev_insn) return prv;
    else                           return cur;
  endfunction

  function automatic logic any_ireq(input ireq_t r, input idec_t d, input logic last_i);
    logic [7:0] hit;
    hit[0] = r.ifetch;
    hit[1] = r.src_pc    & d.src_pc;
    hit[2] = r.dst_pc    & d.dst_pc;
    hit[3] = r.dst_pc_np & d.dst_pc & ~d.prev_insn;
    hit[4] = r.dst_pc_m2 & d.dst_pc & d.dst_m2;
    hit[5] = r.prev_i    & d.prev_insn & ~d.ir15;
    hit[6] = r.cont      & last_i;
    hit[7] = r.con_space;
    return |hit;
  endfunction
endpackage

// File: rtl/bss_mode_pick.sv
module bss_mode_pick
  import bss_pkg::*;
(
  input  logic              kern,
  input  logic              console,
  input  logic              prev_op,
  input  logic              prev_insn,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] prev_mode,
  input  logic [MODE_W-1:0] con_mode,
  output logic [MODE_W-1:0] mode_next
);
  always_comb
    mode_next = pick_mode(kern, console, prev_op, prev_insn, cur_mode, prev_mode, con_mode);
endmodule

// File: rtl/bss_space_pick.sv
module bss_space_pick
  import bss_pkg::*;
(
  input  logic  kern,
  input  ireq_t req,
  input  idec_t dec,
  input  logic  last_i,
  output logic  ispace_next
);
  always_comb
    ispace_next = ~kern & any_ireq(req, dec, last_i);
endmodule

// File: rtl/bss_selector.sv
module bss_selector
  import bss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_start,
  input  logic [1:0] psw_cur_mode,
  input  logic [1:0] psw_prev_mode,
  input  logic [1:0] con_mode,
  input  logic       con_ispace,
  input  logic       ctl_kern_dread,
  input  logic       ctl_console,
  input  logic       ctl_prev_op,
  input  logic       ctl_ifetch,
  input  logic       ctl_src_pc,
  input  logic       ctl_dst_pc,
  input  logic       ctl_dst_pc_np,
  input  logic       ctl_dst_pc_m2,
  input  logic       ctl_prev_i,
  input  logic       ctl_cont,
  input  logic       ctl_con_space,
  input  logic       dec_src_pc,
  input  logic       dec_dst_pc,
  input  logic       dec_dst_m2,
  input  logic       dec_prev_insn,
  input  logic       dec_ir15,
  output logic [1:0] sel_mode,
  output logic       sel_ispace
);
  ireq_t             req;
  idec_t             dec;
  logic [MODE_W-1:0] mode_next;
  logic              ispace_next;
  logic              last_i;

  assign req = '{ifetch: ctl_ifetch, src_pc: ctl_src_pc, dst_pc: ctl_dst_pc,
                 dst_pc_np: ctl_dst_pc_np, dst_pc_m2: ctl_dst_pc_m2,
                 prev_i: ctl_prev_i, cont: ctl_cont,
                 con_space: ctl_con_space & con_ispace};
  assign dec = '{src_pc: dec_src_pc, dst_pc: dec_dst_pc, dst_m2: dec_dst_m2,
                 prev_insn: dec_prev_insn, ir15: dec_ir15};

  bss_mode_pick u_mode (
    .kern(ctl_kern_dread), .console(ctl_console), .prev_op(ctl_prev_op),
    .prev_insn(dec_prev_insn), .cur_mode(psw_cur_mode),
    .prev_mode(psw_prev_mode), .con_mode(con_mode), .mode_next(mode_next));

  bss_space_pick u_space (
    .kern(ctl_kern_dread), .req(req), .dec(dec), .last_i(last_i),
    .ispace_next(ispace_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_mode   <= MODE_KERNEL;
      sel_ispace <= 1'b0;
      last_i     <= 1'b0;
    end else if (cycle_start) begin
      sel_mode   <= mode_next;
      sel_ispace <= ispace_next;
      last_i     <= ispace_next;
    end
  end
endmodule

// File: rtl/bss_selector_chk.sv
module bss_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cycle_start,
  input logic [1:0] con_mode,
  input logic       ctl_kern_dread,
  input logic       ctl_console,
  input logic       ctl_ifetch,
  input logic       ctl_src_pc,
  input logic       ctl_dst_pc,
  input logic       ctl_dst_pc_np,
  input logic       ctl_dst_pc_m2,
  input logic       ctl_prev_i,
  input logic       ctl_cont,
  input logic       ctl_con_space,
  input logic [1:0] sel_mode,
  input logic       sel_ispace
);
  logic no_ireq;
  assign no_ireq = !(ctl_ifetch | ctl_src_pc | ctl_dst_pc | ctl_dst_pc_np |
                     ctl_dst_pc_m2 | ctl_prev_i | ctl_cont | ctl_con_space);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> ($stable(sel_mode) && $stable(sel_ispace)));

  assert_kern_dread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && ctl_kern_dread) |=> (sel_mode == 2'b00 && !sel_ispace));

  assert_console_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && !ctl_kern_dread && ctl_console) |=> (sel_mode == $past(con_mode)));

  assert_ifetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && !ctl_kern_dread && ctl_ifetch) |=> sel_ispace);

  assert_default_d_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && no_ireq) |=> !sel_ispace);
endmodule

bind bss_selector bss_selector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .con_mode(con_mode),
  .ctl_kern_dread(ctl_kern_dread), .ctl_console(ctl_console),
  .ctl_ifetch(ctl_ifetch), .ctl_src_pc(ctl_src_pc), .ctl_dst_pc(ctl_dst_pc),
  .ctl_dst_pc_np(ctl_dst_pc_np), .ctl_dst_pc_m2(ctl_dst_pc_m2),
  .ctl_prev_i(ctl_prev_i), .ctl_cont(ctl_cont), .ctl_con_space(ctl_con_space),
  .sel_mode(sel_mode), .sel_ispace(sel_ispace));

// File: tb/test_bss_selector.sv
module test_bss_selector;
  logic clk = 0, rst_n = 0, cs = 0;
  logic [1:0] cur = 0, prv = 0, cmode = 0;
  logic cisp = 0, kd = 0, con = 0, pop = 0, ifc = 0, spc = 0, dpc = 0, dnp = 0;
  logic dm2 = 0, pi = 0, cnt = 0, csp = 0, d_s = 0, d_d = 0, d_m2 = 0, d_p = 0, d_15 = 0;
  logic [1:0] sel_mode;
  logic sel_ispace;
  int checks = 0, fails = 0;
  int exp_mode = 0, exp_i = 0, exp_last = 0;

  always #5 clk = ~clk;

  bss_selector i_bss_selector (
    .clk(clk), .rst_n(rst_n), .cycle_start(cs), .psw_cur_mode(cur),
    .psw_prev_mode(prv), .con_mode(cmode), .con_ispace(cisp),
    .ctl_kern_dread(kd), .ctl_console(con), .ctl_prev_op(pop), .ctl_ifetch(ifc),
    .ctl_src_pc(spc), .ctl_dst_pc(dpc), .ctl_dst_pc_np(dnp), .ctl_dst_pc_m2(dm2),
    .ctl_prev_i(pi), .ctl_cont(cnt), .ctl_con_space(csp), .dec_src_pc(d_s),
    .dec_dst_pc(d_d), .dec_dst_m2(d_m2), .dec_prev_insn(d_p), .dec_ir15(d_15),
    .sel_mode(sel_mode), .sel_ispace(sel_ispace));

  task automatic clear_in();
    cs = 0; kd = 0; con = 0; pop = 0; ifc = 0; spc = 0; dpc = 0; dnp = 0; dm2 = 0;
    pi = 0; cnt = 0; csp = 0; d_s = 0; d_d = 0; d_m2 = 0; d_p = 0; d_15 = 0; cisp = 0;
  endtask

  // Reference: walks the requirements in order, integer arithmetic only.
  task automatic model_edge();
    int m, i;
    if (!cs) return;
    if (kd) begin m = 0; i = 0; end
    else begin
      if (con) m = cmode;
      else if (pop && d_p) m = prv;
      else m = cur;
      i = 0;
      if (ifc) i = 1;
      if (spc && d_s) i = 1;
      if (dpc && d_d) i = 1;
      if (dnp && d_d && !d_p) i = 1;
      if (dm2 && d_d && d_m2) i = 1;
      if (pi && d_p && !d_15) i = 1;
      if (cnt && exp_last == 1) i = 1;
      if (csp && cisp) i = 1;
    end
    exp_mode = m; exp_i = i; exp_last = i;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (int'(sel_mode) != exp_mode || int'(sel_ispace) != exp_i) begin
      fails++;
      $display("FAIL %s: mode=%0d ispace=%0d expected mode=%0d ispace=%0d",
               tag, sel_mode, sel_ispace, exp_mode, exp_i);
    end
  endtask

  // inputs already set at a negedge; one edge, then compare at next negedge
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic go(input string tag, input int exp_m, input int exp_s);
    step(tag);
    checks++;
    if (int'(sel_mode) != exp_m || int'(sel_ispace) != exp_s) begin
      fails++;
      $display("FAIL %s (direct): mode=%0d ispace=%0d expected mode=%0d ispace=%0d",
               tag, sel_mode, sel_ispace, exp_m, exp_s);
    end
    clear_in();
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    clear_in();
    cur = 2'd3; prv = 2'd1; cmode = 2'd2;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after release");
    // R1/R10: flag starts as D, continuation yields D
    cs = 1; cnt = 1; go("R10 flag reset", 3, 0);
    // R6 default mode, R12 default D
    cs = 1; go("R6 R12 default", 3, 0);
    // R2: no strobe, inputs change, outputs hold
    ifc = 1; con = 1; go("R2 hold", 3, 0);
    // R3 kernel data read overrides everything
    cs = 1; kd = 1; con = 1; ifc = 1; csp = 1; cisp = 1; go("R3 forced", 0, 0);
    // R4 console mode
    cs = 1; con = 1; pop = 1; d_p = 1; go("R4 console", 2, 0);
    // R5 previous mode and its qualification
    cs = 1; pop = 1; d_p = 1; go("R5 prev", 1, 0);
    cs = 1; pop = 1; go("R5 unqualified", 3, 0);
    // R7
    cs = 1; ifc = 1; go("R7 fetch", 3, 1);
    // R8 each qualified form, and unqualified
    cs = 1; spc = 1; d_s = 1; go("R8 src", 3, 1);
    cs = 1; spc = 1; go("R8 src unq", 3, 0);
    cs = 1; dpc = 1; d_d = 1; go("R8 dst", 3, 1);
    cs = 1; dnp = 1; d_d = 1; d_p = 1; go("R8 dst np blocked", 3, 0);
    cs = 1; dnp = 1; d_d = 1; go("R8 dst np", 3, 1);
    cs = 1; dm2 = 1; d_d = 1; go("R8 m2 unq", 3, 0);
    cs = 1; dm2 = 1; d_d = 1; d_m2 = 1; go("R8 m2", 3, 1);
    // R9
    cs = 1; pi = 1; d_p = 1; go("R9 I variant", 3, 1);
    cs = 1; pi = 1; d_p = 1; d_15 = 1; go("R9 D variant", 3, 0);
    // R10 chain: I then continuation keeps I, D then continuation gives D
    cs = 1; ifc = 1; go("R10 set I", 3, 1);
    cs = 1; cnt = 1; go("R10 cont I", 3, 1);
    cs = 1; cnt = 1; go("R10 cont I again", 3, 1);
    cs = 1; kd = 1; go("R10 kernel D", 0, 0);
    cs = 1; cnt = 1; go("R10 cont after kd", 3, 0);
    // R11
    cs = 1; csp = 1; go("R11 sw off", 3, 0);
    cs = 1; csp = 1; cisp = 1; go("R11 sw on", 3, 1);
    // R2 random mix compared each clock
    for (int n = 0; n < 3000; n++) begin
      {cs, kd, con, pop, ifc, spc, dpc, dnp} = 8'($urandom);
      {dm2, pi, cnt, csp, d_s, d_d, d_m2, d_p} = 8'($urandom);
      {d_15, cisp, cur, prv, cmode} = 8'($urandom);
      if (($urandom % 4) != 0) kd = 0;
      if (($urandom % 3) != 0) begin ifc = 0; csp = 0; end
      step("R2 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule